// File: doc/BRIEF.md
# Predicate-Register Branch Predictor

This block is a direct-mapped branch target buffer that does not learn a direction at all. Each entry remembers where a branch jumps and which predicate register the branch tests as its condition. When fetch looks up an address that hits, the remembered register number is sent out on a read port of the predicate register file. The value that register holds at that moment is returned as the taken/not-taken prediction, together with the stored target. When the compare feeding the branch has already executed, the prediction is exact. When it has not, the older value still in the register is used without stalling. Code can therefore steer the prediction by writing that register early.

Entries are created only from the resolve port, and only when a branch is reported as mispredicted. A correctly predicted branch that has no entry never takes one. The buffer is indexed by the branch address bits just above the instruction alignment bits, and the remaining upper bits form the tag. One parameter inserts an extra pipeline cycle between the table lookup and the predicate read, so that predicate writes landing one cycle later are still seen. A second parameter selects a write-through bypass. With the bypass on, a predicate written in the same cycle as the read supplies the prediction.

Top module: `predreg_bp`

## Requirements
- R1: While reset (rst_n low) is applied, every entry becomes invalid. Every lookup after reset misses until a new allocation is made, and pred_valid is low during and directly after reset.
- R2: pred_valid is high exactly 1 + EXTRA_DELAY cycles after a cycle with lookup_valid high, and low otherwise.
- R3: On a miss, pred_hit = 0, pred_taken = 0 and pred_target = 0.
- R4: A cycle with upd_valid = 1 and upd_mispredict = 1 writes the entry at index upd_pc[ALIGN_BITS+IDX_W-1:ALIGN_BITS] (IDX_W = log2 ENTRIES). The entry takes the tag upd_pc[ADDR_W-1:ALIGN_BITS+IDX_W], the target upd_target and the register number upd_pidx. A later lookup of that address hits and returns upd_target.
- R5: An update with upd_mispredict = 0 neither allocates nor changes an entry. A previously missing address still misses, and an existing entry keeps its target and register number.
- R6: On a hit, prf_rd_idx carries the stored register number in the read cycle, and pred_taken equals prf_rd_val from that cycle.
- R7: The prediction uses whatever value the register holds at read time, with no stall. A value written earlier through the predicate write port is reflected on the next lookup.
- R8: A lookup whose index matches an entry but whose tag differs misses.
- R9: A further mispredicted update to an existing entry replaces its target and register number.
- R10: With WR_BYPASS = 1, a predicate write (prf_wr_en) to the register being read in the same cycle makes pred_taken equal prf_wr_val. With WR_BYPASS = 0, the read value prf_rd_val is used.
- R11: With EXTRA_DELAY = 1, the predicate is read one cycle after the lookup. A write committed at the end of the lookup cycle is therefore seen by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Fetch lookup request |
| lookup_pc | input | ADDR_W | Branch address to look up |
| pred_valid | output | 1 | Prediction result valid |
| pred_hit | output | 1 | Lookup found a matching entry |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_target | output | ADDR_W | Predicted target, 0 on a miss |
| prf_rd_idx | output | PIDX_W | Predicate register file read address |
| prf_rd_val | input | 1 | Predicate register file read data |
| prf_wr_en | input | 1 | Predicate write happening this cycle |
| prf_wr_idx | input | PIDX_W | Register number of that write |
| prf_wr_val | input | 1 | Value of that write |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | ADDR_W | Resolved branch address |
| upd_target | input | ADDR_W | Resolved branch target |
| upd_pidx | input | PIDX_W | Predicate register the branch tests |
| upd_mispredict | input | 1 | The branch was mispredicted |

## Verification
Wrong state in this block shows as a wrong hit flag, target or register number on the first lookup after the corrupting event. A lost valid bit makes an allocated branch miss. A stale tag makes an aliasing address hit. A wrong stored register number drives the wrong prf_rd_idx and so flips pred_taken when neighbouring registers hold different values. Timing faults in the predicate path show up within one or two cycles of a lookup. A predicate write is then either seen or missed against the bypass and delay settings, which the bench checks by writing the tested register in the lookup cycle and in the cycle after it.

// File: rtl/predreg_bp_pkg.sv
package predreg_bp_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_ENTRIES    = 1024;
    localparam int unsigned DEF_PREG_COUNT = 64;
    localparam int unsigned DEF_ALIGN_BITS = 2;

    // Predicate value selection: bypass from the write port or plain read.
    function automatic logic pick_pred(input logic bypass_on,
                                       input logic wr_en,
                                       input logic wr_match,
                                       input logic wr_val,
                                       input logic rd_val);
        return (bypass_on && wr_en && wr_match) ? wr_val : rd_val;
    endfunction
endpackage

// File: rtl/predreg_bp_store.sv
module predreg_bp_store #(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned TAG_W   = 20,
    parameter int unsigned TGT_W   = 32,
    parameter int unsigned PIDX_W  = 6,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_index,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [TGT_W-1:0]  rd_target,
    output logic [PIDX_W-1:0] rd_pidx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TGT_W-1:0]  wr_target,
    input  logic [PIDX_W-1:0] wr_pidx
);
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_mem  [ENTRIES];
    logic [TGT_W-1:0]   tgt_mem  [ENTRIES];
    logic [PIDX_W-1:0]  pidx_mem [ENTRIES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_index] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_index]  <= wr_tag;
            tgt_mem[wr_index]  <= wr_target;
            pidx_mem[wr_index] <= wr_pidx;
        end
    end

    assign rd_valid  = valid_q[rd_index];
    assign rd_tag    = tag_mem[rd_index];
    assign rd_target = tgt_mem[rd_index];
    assign rd_pidx   = pidx_mem[rd_index];

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    assert_alloc_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_index)]);

    assert_no_write_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/predreg_bp_read.sv
module predreg_bp_read #(
    parameter int unsigned TGT_W       = 32,
    parameter int unsigned PIDX_W      = 6,
    parameter bit          EXTRA_DELAY = 1'b0,
    parameter bit          WR_BYPASS   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_hit,
    input  logic [TGT_W-1:0]  in_tgt,
    input  logic [PIDX_W-1:0] in_pidx,
    output logic [PIDX_W-1:0] prf_rd_idx,
    input  logic              prf_rd_val,
    input  logic              prf_wr_en,
    input  logic [PIDX_W-1:0] prf_wr_idx,
    input  logic              prf_wr_val,
    output logic              out_vld,
    output logic              out_hit,
    output logic              out_taken,
    output logic [TGT_W-1:0]  out_tgt
);
    import predreg_bp_pkg::*;

    localparam int unsigned LAT = EXTRA_DELAY ? 2 : 1;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [TGT_W-1:0]  tgt;
        logic [PIDX_W-1:0] pidx;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        logic              vld;
        logic              hit;
        logic              taken;
        logic [TGT_W-1:0]  tgt;
    } regs_t;

    regs_t  r_d, r_q;
    stage_t in_s, rd_s;
    logic   pred_bit;

    always_comb begin
        in_s.vld  = in_vld;
        in_s.hit  = in_vld & in_hit;
        in_s.tgt  = in_tgt;
        in_s.pidx = in_pidx;
    end

    generate
        if (EXTRA_DELAY) begin : g_late_read
            assign rd_s = r_q.s1;
        end else begin : g_early_read
            assign rd_s = in_s;
        end
    endgenerate

    assign prf_rd_idx = rd_s.pidx;

    always_comb begin
        pred_bit = pick_pred(WR_BYPASS, prf_wr_en, (prf_wr_idx == rd_s.pidx),
                             prf_wr_val, prf_rd_val);
        r_d       = r_q;
        r_d.s1    = EXTRA_DELAY ? in_s : '0;
        r_d.vld   = rd_s.vld;
        r_d.hit   = rd_s.vld & rd_s.hit;
        r_d.taken = rd_s.vld & rd_s.hit & pred_bit;
        r_d.tgt   = (rd_s.vld & rd_s.hit) ? rd_s.tgt : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_vld   = r_q.vld;
    assign out_hit   = r_q.hit;
    assign out_taken = r_q.taken;
    assign out_tgt   = r_q.tgt;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld, LAT));

    assert_hit_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s.vld && rd_s.hit && !(WR_BYPASS && prf_wr_en && prf_wr_idx == rd_s.pidx))
        |=> (out_taken == $past(prf_rd_val)));

    generate
        if (WR_BYPASS) begin : g_bypass_chk
            assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_s.vld && rd_s.hit && prf_wr_en && prf_wr_idx == rd_s.pidx)
                |=> (out_taken == $past(prf_wr_val)));
        end
    endgenerate
endmodule

// File: rtl/predreg_bp.sv
module predreg_bp #(
    parameter int unsigned ADDR_W      = predreg_bp_pkg::DEF_ADDR_W,
    parameter int unsigned ENTRIES     = predreg_bp_pkg::DEF_ENTRIES,
    parameter int unsigned PREG_COUNT  = predreg_bp_pkg::DEF_PREG_COUNT,
    parameter int unsigned ALIGN_BITS  = predreg_bp_pkg::DEF_ALIGN_BITS,
    parameter bit          EXTRA_DELAY = 1'b0,
    parameter bit          WR_BYPASS   = 1'b1,
    localparam int unsigned IDX_W      = $clog2(ENTRIES),
    localparam int unsigned PIDX_W     = $clog2(PREG_COUNT),
    localparam int unsigned TAG_LO     = ALIGN_BITS + IDX_W,
    localparam int unsigned TAG_W      = ADDR_W - TAG_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_pc,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [PIDX_W-1:0] prf_rd_idx,
    input  logic              prf_rd_val,
    input  logic              prf_wr_en,
    input  logic [PIDX_W-1:0] prf_wr_idx,
    input  logic              prf_wr_val,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic [PIDX_W-1:0] upd_pidx,
    input  logic              upd_mispredict
);
    logic [IDX_W-1:0]  lk_index;
    logic [TAG_W-1:0]  lk_tag;
    logic              ent_valid;
    logic [TAG_W-1:0]  ent_tag;
    logic [ADDR_W-1:0] ent_target;
    logic [PIDX_W-1:0] ent_pidx;
    logic              lk_hit;
    logic              alloc_en;

    assign lk_index = lookup_pc[TAG_LO-1:ALIGN_BITS];
    assign lk_tag   = lookup_pc[ADDR_W-1:TAG_LO];
    assign lk_hit   = ent_valid && (ent_tag == lk_tag);
    assign alloc_en = upd_valid && upd_mispredict;

    predreg_bp_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .TGT_W   (ADDR_W),
        .PIDX_W  (PIDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_index  (lk_index),
        .rd_valid  (ent_valid),
        .rd_tag    (ent_tag),
        .rd_target (ent_target),
        .rd_pidx   (ent_pidx),
        .wr_en     (alloc_en),
        .wr_index  (upd_pc[TAG_LO-1:ALIGN_BITS]),
        .wr_tag    (upd_pc[ADDR_W-1:TAG_LO]),
        .wr_target (upd_target),
        .wr_pidx   (upd_pidx)
    );

    predreg_bp_read #(
        .TGT_W       (ADDR_W),
        .PIDX_W      (PIDX_W),
        .EXTRA_DELAY (EXTRA_DELAY),
        .WR_BYPASS   (WR_BYPASS)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (lookup_valid),
        .in_hit     (lk_hit),
        .in_tgt     (ent_target),
        .in_pidx    (ent_pidx),
        .prf_rd_idx (prf_rd_idx),
        .prf_rd_val (prf_rd_val),
        .prf_wr_en  (prf_wr_en),
        .prf_wr_idx (prf_wr_idx),
        .prf_wr_val (prf_wr_val),
        .out_vld    (pred_valid),
        .out_hit    (pred_hit),
        .out_taken  (pred_taken),
        .out_tgt    (pred_target)
    );

    assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_hit) |-> (!pred_taken && pred_target == '0));

    assert_hit_only_when_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_valid);
endmodule

// File: tb/predreg_bp_tb.sv
module predreg_bp_tb;
    localparam int AW = 32;
    localparam int PW = 6;

    typedef struct packed {
        logic          is_upd;
        logic [AW-1:0] pc;
        logic [AW-1:0] tgt;
        logic [PW-1:0] pidx;
        logic          mis;
        logic          e_hit;
        logic          e_taken;
        logic [AW-1:0] e_tgt;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 13;
    // Register file starts with odd registers = 1, even = 0.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h1000, 32'h0,    6'd0, 1'b0, 1'b0, 1'b0, 32'h0,    8'd3}, // R3 miss
        '{1'b1, 32'h1000, 32'h2000, 6'd5, 1'b0, 1'b0, 1'b0, 32'h0,    8'd5}, // no alloc
        '{1'b0, 32'h1000, 32'h0,    6'd0, 1'b0, 1'b0, 1'b0, 32'h0,    8'd5}, // R5 still miss
        '{1'b1, 32'h1000, 32'h2000, 6'd5, 1'b1, 1'b0, 1'b0, 32'h0,    8'd4}, // alloc
        '{1'b0, 32'h1000, 32'h0,    6'd0, 1'b0, 1'b1, 1'b1, 32'h2000, 8'd4}, // R4 / R6
        '{1'b0, 32'h2000, 32'h0,    6'd0, 1'b0, 1'b0, 1'b0, 32'h0,    8'd8}, // R8 alias
        '{1'b1, 32'h1000, 32'h3000, 6'd6, 1'b1, 1'b0, 1'b0, 32'h0,    8'd9}, // overwrite
        '{1'b0, 32'h1000, 32'h0,    6'd0, 1'b0, 1'b1, 1'b0, 32'h3000, 8'd9}, // R9
        '{1'b1, 32'h1004, 32'h4440, 6'd9, 1'b1, 1'b0, 1'b0, 32'h0,    8'd4}, // alloc 2nd
        '{1'b0, 32'h1004, 32'h0,    6'd0, 1'b0, 1'b1, 1'b1, 32'h4440, 8'd6}, // R6
        '{1'b0, 32'h1000, 32'h0,    6'd0, 1'b0, 1'b1, 1'b0, 32'h3000, 8'd4}, // R4 neighbour kept
        '{1'b1, 32'h1004, 32'h9990, 6'd2, 1'b0, 1'b0, 1'b0, 32'h0,    8'd5}, // correct, no change
        '{1'b0, 32'h1004, 32'h0,    6'd0, 1'b0, 1'b1, 1'b1, 32'h4440, 8'd5}  // R5 kept
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lookup_valid = 1'b0;
    logic [AW-1:0] lookup_pc = '0;
    logic          prf_wr_en = 1'b0;
    logic [PW-1:0] prf_wr_idx = '0;
    logic          prf_wr_val = 1'b0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic [PW-1:0] upd_pidx = '0;
    logic          upd_mispredict = 1'b0;

    logic          a_vld, a_hit, a_tk, b_vld, b_hit, b_tk;
    logic [AW-1:0] a_tgt, b_tgt;
    logic [PW-1:0] a_ridx, b_ridx;
    logic          a_rval, b_rval;
    logic          prf_mem [64];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) prf_mem[i] <= i[0];
        end else if (prf_wr_en) begin
            prf_mem[prf_wr_idx] <= prf_wr_val;
        end
    end

    assign a_rval = prf_mem[a_ridx];
    assign b_rval = prf_mem[b_ridx];

    predreg_bp u_dut (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .pred_valid(a_vld), .pred_hit(a_hit), .pred_taken(a_tk), .pred_target(a_tgt),
        .prf_rd_idx(a_ridx), .prf_rd_val(a_rval), .prf_wr_en(prf_wr_en),
        .prf_wr_idx(prf_wr_idx), .prf_wr_val(prf_wr_val), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_pidx(upd_pidx),
        .upd_mispredict(upd_mispredict)
    );

    predreg_bp #(.EXTRA_DELAY(1'b1), .WR_BYPASS(1'b0)) u_dut_late (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .pred_valid(b_vld), .pred_hit(b_hit), .pred_taken(b_tk), .pred_target(b_tgt),
        .prf_rd_idx(b_ridx), .prf_rd_val(b_rval), .prf_wr_en(prf_wr_en),
        .prf_wr_idx(prf_wr_idx), .prf_wr_val(prf_wr_val), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_pidx(upd_pidx),
        .upd_mispredict(upd_mispredict)
    );

    task automatic check(input string tag, input logic [AW+2:0] act, input logic [AW+2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 reset outputs", {a_vld, a_hit, a_tk, a_tgt}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].is_upd) begin
                upd_valid = 1'b1; upd_pc = VECS[v].pc; upd_target = VECS[v].tgt;
                upd_pidx = VECS[v].pidx; upd_mispredict = VECS[v].mis;
                @(negedge clk);
                upd_valid = 1'b0; upd_mispredict = 1'b0;
            end else begin
                lookup_valid = 1'b1; lookup_pc = VECS[v].pc;
                @(negedge clk);
                lookup_valid = 1'b0;
                check($sformatf("R%0d vector %0d", VECS[v].req, v),
                      {a_vld, a_hit, a_tk, a_tgt},
                      {1'b1, VECS[v].e_hit, VECS[v].e_taken, VECS[v].e_tgt});
            end
        end

        // R2: valid only for the one cycle after the request
        @(negedge clk);
        check("R2 idle valid", {2'b0, a_vld}, '0);

        // R7: earlier write to reg 6 (entry 0x1000) is seen by next lookup
        prf_wr_en = 1'b1; prf_wr_idx = 6'd6; prf_wr_val = 1'b1;
        @(negedge clk);
        prf_wr_en = 1'b0;
        lookup_valid = 1'b1; lookup_pc = 32'h1000;
        @(negedge clk);
        lookup_valid = 1'b0;
        check("R7 new value used", {a_vld, a_hit, a_tk, a_tgt}, {3'b111, 32'h3000});

        // R10: same-cycle write is bypassed on the default instance
        lookup_valid = 1'b1; lookup_pc = 32'h1000;
        prf_wr_en = 1'b1; prf_wr_idx = 6'd6; prf_wr_val = 1'b0;
        @(negedge clk);
        lookup_valid = 1'b0; prf_wr_en = 1'b0;
        check("R10 bypass", {2'b0, a_tk}, '0);
        @(negedge clk);
        check("R2 late instance valid", {b_vld, b_hit, b_tk}, {3'b110});

        // R11: write in the lookup cycle seen by late-read instance
        lookup_valid = 1'b1; lookup_pc = 32'h1000;
        prf_wr_en = 1'b1; prf_wr_idx = 6'd6; prf_wr_val = 1'b1;
        @(negedge clk);
        lookup_valid = 1'b0; prf_wr_en = 1'b0;
        check("R2 late not yet valid", {2'b0, b_vld}, '0);
        @(negedge clk);
        check("R11 late read", {b_vld, b_hit, b_tk, b_tgt}, {3'b111, 32'h3000});

        // R10 (bypass off): write during the late read cycle is not used
        lookup_valid = 1'b1; lookup_pc = 32'h1000;
        @(negedge clk);
        lookup_valid = 1'b0;
        prf_wr_en = 1'b1; prf_wr_idx = 6'd6; prf_wr_val = 1'b0;
        @(negedge clk);
        prf_wr_en = 1'b0;
        check("R10 no bypass", {2'b0, b_tk}, 3'b001);

        // R1: reset again clears the entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup_valid = 1'b1; lookup_pc = 32'h1000;
        @(negedge clk);
        lookup_valid = 1'b0;
        check("R1 cleared after reset", {a_vld, a_hit, a_tk, a_tgt}, {3'b100, 32'h0});
        @(negedge clk);
        check("R1 cleared late instance", {b_vld, b_hit, b_tk, b_tgt}, {3'b100, 32'h0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule